// File: doc/BRIEF.md
# Multi-Cycle 16-Bit Register-File Processor

This block is a small programmable processor made of a controller state machine and one datapath. The datapath holds a program counter, an instruction register, a sixteen-entry register file with one write port and two read ports, and a single ALU that raises a zero flag. The processor shares one word-addressed memory for instructions and data. That memory is external, reads synchronously, and returns data one cycle after the request.

Every instruction is one 16-bit word. The top four bits are the opcode. Bits 11..8 name the first register, called here the target register. Bits 7..4 name the second register, called here the source register. Bits 7..0 also serve as an 8-bit byte field, which is zero-extended to 16 bits. An instruction passes through a fetch request, a fetch capture, a decode step and an execute step, and then returns to fetch. A load from memory adds one cycle to its execute step so that the read data can arrive.

Top module: `rt_cpu16`

## Requirements
- R1: A synchronous active-high reset clears the program counter to 0. On the first cycle after reset is released, the block issues a read at address 0 with the write strobe low.
- R2: Instruction fetches read consecutive addresses. A read and a write are never requested in the same cycle. Every read request is followed by a cycle with no read request.
- R3: Opcode 0000 loads the target register from memory at the zero-extended byte field.
- R4: Opcode 0001 writes the target register to memory at the zero-extended byte field, with a write strobe that lasts exactly one cycle.
- R5: Opcode 0010 writes the source register to the memory address held in the target register.
- R6: Opcode 0011 loads the target register with the byte field, zero-extended.
- R7: Opcode 0100 sets target = target + source, wrapping modulo 2^16.
- R8: Opcode 0101 sets target = target − source, wrapping modulo 2^16.
- R9: When the target register is zero, opcode 0110 sets the program counter to the zero-extended byte field. When it is not zero, execution continues with the next word.
- R10: Opcodes 0111 through 1111 change no register and no memory location. The next fetch follows 3 cycles after the fetch of such an opcode.
- R11: The next fetch follows 4 cycles after the fetch of opcodes 0001 to 0110, and 5 cycles after the fetch of opcode 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid one cycle after a read request |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write strobe |

## Verification
A corrupted program counter appears at the ports as a wrong fetch address on the next read request, within four or five cycles. A wrong register value or a wrong ALU result stays hidden until a store places it on the write data lines, or until a zero-test jump sends the following fetch to the wrong address. The tests therefore end each program by storing the results. A wrong next state in the controller changes the spacing between fetches or produces a stray read or write strobe, and this shows in the next cycle.

// File: rtl/rt_cpu16_pkg.sv
package rt_cpu16_pkg;

  localparam int WORD_W = 16;
  localparam int OP_W   = 4;
  localparam int BYTE_W = 8;

  localparam logic [OP_W-1:0] OPC_LDD = 4'h0;
  localparam logic [OP_W-1:0] OPC_STD = 4'h1;
  localparam logic [OP_W-1:0] OPC_STI = 4'h2;
  localparam logic [OP_W-1:0] OPC_LDI = 4'h3;
  localparam logic [OP_W-1:0] OPC_ADD = 4'h4;
  localparam logic [OP_W-1:0] OPC_SUB = 4'h5;
  localparam logic [OP_W-1:0] OPC_JZ  = 4'h6;

  localparam logic [1:0] WSEL_ALU = 2'b00;
  localparam logic [1:0] WSEL_MEM = 2'b01;
  localparam logic [1:0] WSEL_IMM = 2'b10;

  localparam logic [1:0] ALU_ADD  = 2'b00;
  localparam logic [1:0] ALU_SUB  = 2'b01;
  localparam logic [1:0] ALU_PASS = 2'b10;

  localparam logic [1:0] ASEL_PC  = 2'b00;
  localparam logic [1:0] ASEL_DIR = 2'b01;
  localparam logic [1:0] ASEL_REG = 2'b10;

  typedef enum logic [3:0] {
    ST_FETCH, ST_FWAIT, ST_DECODE, ST_LDD, ST_LWAIT,
    ST_STD, ST_STI, ST_LDI, ST_ADD, ST_SUB, ST_JZ
  } state_e;

  typedef struct packed {
    logic       ir_ld;
    logic       pc_inc;
    logic       pc_ld_z;
    logic       rf_we;
    logic [1:0] rf_wsel;
    logic [1:0] alu_sel;
    logic [1:0] addr_sel;
    logic       wd_src2;
    logic       mem_re;
    logic       mem_we;
  } ctrl_t;

endpackage

// File: rtl/rt_regfile.sv
module rt_regfile #(
  parameter int DW  = 16,
  parameter int RAW = 4
) (
  input  logic           clk,
  input  logic           we,
  input  logic [RAW-1:0] wa,
  input  logic [DW-1:0]  wd,
  input  logic [RAW-1:0] ra1,
  input  logic [RAW-1:0] ra2,
  output logic [DW-1:0]  rd1,
  output logic [DW-1:0]  rd2
);
  localparam int DEPTH = 1 << RAW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[wa] <= wd;
  end

  assign rd1 = cells[ra1];
  assign rd2 = cells[ra2];
endmodule

// File: rtl/rt_alu.sv
module rt_alu
  import rt_cpu16_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [1:0]    sel,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y,
  output logic          zero
);
  always_comb begin
    case (sel)
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_PASS: y = a;
      default:  y = '0;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/rt_ctrl.sv
module rt_ctrl
  import rt_cpu16_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  output state_e          state,
  output ctrl_t           ctl
);
  state_e state_q, state_d;

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_FETCH;
    else     state_q <= state_d;
  end

  assign state = state_q;

  always_comb begin
    state_d = ST_FETCH;
    case (state_q)
      ST_FETCH:  state_d = ST_FWAIT;
      ST_FWAIT:  state_d = ST_DECODE;
      ST_DECODE: begin
        case (opcode)
          OPC_LDD: state_d = ST_LDD;
          OPC_STD: state_d = ST_STD;
          OPC_STI: state_d = ST_STI;
          OPC_LDI: state_d = ST_LDI;
          OPC_ADD: state_d = ST_ADD;
          OPC_SUB: state_d = ST_SUB;
          OPC_JZ:  state_d = ST_JZ;
          default: state_d = ST_FETCH;
        endcase
      end
      ST_LDD:    state_d = ST_LWAIT;
      default:   state_d = ST_FETCH;
    endcase
  end

  always_comb begin
    ctl = '0;
    case (state_q)
      ST_FETCH: begin
        ctl.addr_sel = ASEL_PC;
        ctl.mem_re   = 1'b1;
        ctl.pc_inc   = 1'b1;
      end
      ST_FWAIT: ctl.ir_ld = 1'b1;
      ST_LDD: begin
        ctl.addr_sel = ASEL_DIR;
        ctl.mem_re   = 1'b1;
      end
      ST_LWAIT: begin
        ctl.rf_we   = 1'b1;
        ctl.rf_wsel = WSEL_MEM;
      end
      ST_STD: begin
        ctl.addr_sel = ASEL_DIR;
        ctl.mem_we   = 1'b1;
      end
      ST_STI: begin
        ctl.addr_sel = ASEL_REG;
        ctl.wd_src2  = 1'b1;
        ctl.mem_we   = 1'b1;
      end
      ST_LDI: begin
        ctl.rf_we   = 1'b1;
        ctl.rf_wsel = WSEL_IMM;
      end
      ST_ADD: begin
        ctl.rf_we   = 1'b1;
        ctl.rf_wsel = WSEL_ALU;
        ctl.alu_sel = ALU_ADD;
      end
      ST_SUB: begin
        ctl.rf_we   = 1'b1;
        ctl.rf_wsel = WSEL_ALU;
        ctl.alu_sel = ALU_SUB;
      end
      ST_JZ: begin
        ctl.alu_sel = ALU_PASS;
        ctl.pc_ld_z = 1'b1;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/rt_cpu16.sv
module rt_cpu16
  import rt_cpu16_pkg::*;
#(
  parameter int DW  = WORD_W,
  parameter int AW  = 16,
  parameter int RAW = 4
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_re,
  output logic          mem_we
);
  localparam int OP_LSB = DW - OP_W;
  localparam int RN_LSB = OP_LSB - RAW;
  localparam int RM_LSB = RN_LSB - RAW;

  state_e          state;
  ctrl_t           ctl;
  logic [AW-1:0]   pc_q;
  logic [DW-1:0]   ir_q;
  logic [RAW-1:0]  rn, rm;
  logic [DW-1:0]   rd1, rd2, alu_y, wdata_rf;
  logic [DW-1:0]   byte_dw;
  logic [AW-1:0]   byte_aw;
  logic            alu_zero;
  logic            jz_go;

  assign rn      = ir_q[RN_LSB +: RAW];
  assign rm      = ir_q[RM_LSB +: RAW];
  assign byte_dw = {{(DW-BYTE_W){1'b0}}, ir_q[BYTE_W-1:0]};
  assign byte_aw = {{(AW-BYTE_W){1'b0}}, ir_q[BYTE_W-1:0]};

  rt_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opcode (ir_q[OP_LSB +: OP_W]),
    .state  (state),
    .ctl    (ctl)
  );

  rt_regfile #(.DW(DW), .RAW(RAW)) u_rf (
    .clk (clk),
    .we  (ctl.rf_we),
    .wa  (rn),
    .wd  (wdata_rf),
    .ra1 (rn),
    .ra2 (rm),
    .rd1 (rd1),
    .rd2 (rd2)
  );

  rt_alu #(.DW(DW)) u_alu (
    .sel  (ctl.alu_sel),
    .a    (rd1),
    .b    (rd2),
    .y    (alu_y),
    .zero (alu_zero)
  );

  always_comb begin
    case (ctl.rf_wsel)
      WSEL_MEM: wdata_rf = mem_rdata;
      WSEL_IMM: wdata_rf = byte_dw;
      default:  wdata_rf = alu_y;
    endcase
  end

  assign jz_go = ctl.pc_ld_z & alu_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
      ir_q <= '0;
    end else begin
      if (ctl.ir_ld)   ir_q <= mem_rdata;
      if (ctl.pc_inc)  pc_q <= pc_q + 1'b1;
      else if (jz_go)  pc_q <= byte_aw;
    end
  end

  always_comb begin
    case (ctl.addr_sel)
      ASEL_DIR: mem_addr = byte_aw;
      ASEL_REG: mem_addr = rd1[AW-1:0];
      default:  mem_addr = pc_q;
    endcase
  end

  assign mem_wdata = ctl.wd_src2 ? rd2 : rd1;
  assign mem_re    = ctl.mem_re;
  assign mem_we    = ctl.mem_we;

endmodule

// File: rtl/rt_cpu16_chk.sv
module rt_cpu16_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_re,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          jz_go,
  input logic [AW-1:0] pc,
  input logic [7:0]    ir_byte
);
  assert_first_fetch_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mem_re && !mem_we && mem_addr == '0));

  assert_rw_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we));

  assert_read_gap_R2: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> !mem_re);

  assert_write_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  assert_jump_target_R9: assert property (@(posedge clk) disable iff (rst)
    jz_go |=> (pc == {{(AW-8){1'b0}}, $past(ir_byte)}));
endmodule

bind rt_cpu16 rt_cpu16_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mem_re   (mem_re),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .jz_go    (jz_go),
  .pc       (pc_q),
  .ir_byte  (ir_q[7:0])
);

// File: tb/sim_rt_cpu16.sv
module sim_rt_cpu16;
  localparam int CLK_NS = 10;
  localparam int MEMW   = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_re, mem_we;
  logic [15:0] mem [MEMW];
  int          checks = 0;
  int          errors = 0;
  int          wr_count = 0;
  int          pp;

  always #(CLK_NS/2) clk = ~clk;

  rt_cpu16 u0 (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_re(mem_re), .mem_we(mem_we)
  );

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr[9:0]] <= mem_wdata;
      wr_count <= wr_count + 1;
    end
    if (mem_re) mem_rdata <= mem[mem_addr[9:0]];
  end

  function automatic logic [15:0] ib(logic [3:0] op, logic [3:0] a, logic [7:0] b);
    return {op, a, b};
  endfunction

  function automatic logic [15:0] ir2(logic [3:0] op, logic [3:0] a, logic [3:0] b);
    return {op, a, b, 4'h0};
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(logic [15:0] w);
    mem[pp] = w;
    pp++;
  endtask

  task automatic put_halt();
    put(ib(4'h3, 4'hF, 8'h00));
    put(ib(4'h6, 4'hF, 8'(pp)));
  endtask

  task automatic begin_prog();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < MEMW; i++) mem[i] = 16'h0;
    pp = 0;
  endtask

  task automatic release_and_run(int cyc);
    @(negedge clk);
    rst = 1'b0;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic t_reset();
    begin_prog();
    put(ib(4'h3, 4'h1, 8'h01));
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 first addr", mem_addr, 16'h0000);
    check("R1 read req", {15'b0, mem_re}, 16'h1);
    check("R1 no write", {15'b0, mem_we}, 16'h0);
  endtask

  task automatic t_moves();
    begin_prog();
    mem[16'hC8] = 16'h1234;
    put(ib(4'h3, 4'h1, 8'h5A));
    put(ib(4'h0, 4'h2, 8'hC8));
    put(ib(4'h1, 4'h2, 8'hC9));
    put(ib(4'h1, 4'h1, 8'hCA));
    put_halt();
    release_and_run(80);
    check("R3 load direct", mem[16'hC9], 16'h1234);
    check("R6 immediate zero-extended", mem[16'hCA], 16'h005A);
    check("R4 source word unchanged", mem[16'hC8], 16'h1234);
  endtask

  task automatic t_arith();
    begin_prog();
    put(ib(4'h3, 4'h3, 8'h00));
    put(ib(4'h3, 4'h4, 8'h01));
    put(ir2(4'h5, 4'h3, 4'h4));
    put(ib(4'h1, 4'h3, 8'hD0));
    put(ir2(4'h4, 4'h3, 4'h4));
    put(ib(4'h1, 4'h3, 8'hD1));
    put(ib(4'h3, 4'h6, 8'h80));
    put(ib(4'h3, 4'h7, 8'h7F));
    put(ir2(4'h4, 4'h6, 4'h7));
    put(ib(4'h1, 4'h6, 8'hD2));
    put(ir2(4'h5, 4'h7, 4'h6));
    put(ib(4'h1, 4'h7, 8'hD3));
    put_halt();
    release_and_run(120);
    check("R8 sub underflow wraps", mem[16'hD0], 16'hFFFF);
    check("R7 add overflow wraps", mem[16'hD1], 16'h0000);
    check("R7 add", mem[16'hD2], 16'h00FF);
    check("R8 sub", mem[16'hD3], 16'hFF80);
  endtask

  task automatic t_indirect();
    begin_prog();
    put(ib(4'h3, 4'h1, 8'hE0));
    put(ib(4'h3, 4'h2, 8'hAB));
    put(ir2(4'h2, 4'h1, 4'h2));
    put_halt();
    release_and_run(60);
    check("R5 indirect store", mem[16'hE0], 16'h00AB);
  endtask

  task automatic t_jump();
    begin_prog();
    put(ib(4'h3, 4'h1, 8'h00));
    put(ib(4'h3, 4'h2, 8'h05));
    put(ib(4'h6, 4'h2, 8'h06));
    put(ib(4'h3, 4'h3, 8'h11));
    put(ib(4'h6, 4'h1, 8'h07));
    put(ib(4'h3, 4'h3, 8'h22));
    put(ib(4'h3, 4'h3, 8'h33));
    put(ib(4'h1, 4'h3, 8'hF0));
    put_halt();
    release_and_run(80);
    check("R9 not-taken then taken", mem[16'hF0], 16'h0011);
  endtask

  task automatic t_undef();
    int w0;
    begin_prog();
    put(ib(4'h3, 4'h1, 8'h42));
    put(16'h7123);
    put(16'hFFFF);
    put(ib(4'h1, 4'h1, 8'hF8));
    put_halt();
    w0 = wr_count;
    release_and_run(60);
    check("R10 register kept", mem[16'hF8], 16'h0042);
    check("R10 single write only", 16'(wr_count - w0), 16'd1);
  endtask

  task automatic t_gap(logic [15:0] word0, int exp, string req);
    int n;
    begin_prog();
    put(word0);
    put_halt();
    @(negedge clk);
    rst = 1'b0;
    n = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      n++;
      if (mem_re && mem_addr == 16'h0001) break;
    end
    check(req, 16'(n), 16'(exp));
  endtask

  initial begin
    #(CLK_NS * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_moves();
    t_arith();
    t_indirect();
    t_jump();
    t_undef();
    t_gap(ib(4'h3, 4'h1, 8'h01), 4, "R11 immediate spacing");
    t_gap(ib(4'h0, 4'h1, 8'h10), 5, "R11 load spacing");
    t_gap(ib(4'h1, 4'h1, 8'h10), 4, "R11 store spacing");
    t_gap(16'hA000, 3, "R10 undefined spacing");
    t_gap(ib(4'h3, 4'h1, 8'h01), 4, "R2 fetch next address");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule